// File: doc/BRIEF.md
# Byte-Lane Coherent Sample Port

This block connects a byte-addressed peripheral bus to a 24-bit datapath engine, such as a digital filter. A processor or DMA writes each input sample into a three-lane staging word, one byte or one 16-bit half at a time. Lanes that are written ahead of time collect in a shadow. When the selected key lane is written, the complete word goes to the engine with a one-cycle valid strobe. If the key lane is never touched, the engine never sees a sample.

On the result side, each word from the engine is captured into a holding register, and a ready flag is raised. That flag can drive an interrupt or a DMA request. When the bus reads the key lane, it gets the live result and the result is frozen into a read shadow at the same time. All other lanes are then read from that shadow, so a newer result cannot tear a word that is partly read.

Two align switches set where 16-bit accesses land. On the write side, a 16-bit write can target the upper two lanes instead of the lower two. On the read side, the upper 16 result bits can be presented in the lower two lanes. In both cases a single 16-bit transfer moves the useful part of the sample.

Top module: `stage_hold_port`

## Requirements
- R1: After a synchronous active-high reset, `engData`, `engValid`, `holdReady` and all readback are zero.
- R2: A write that does not include the staging key lane updates only the staging shadow: `engValid` stays low and `engData` keeps its value.
- R3: A write that includes the staging key lane commits all three lanes to `engData` one cycle later. The committed word merges the newly written bytes with the shadow. `engValid` is high for exactly that one cycle.
- R4: A 16-bit write with `stageAlign`=0 puts `busWData[15:8]` in the middle lane and `busWData[7:0]` in the low lane. With `stageAlign`=1 it puts them in the high and middle lanes.
- R5: A byte access at `busAddr` 0/1/2 addresses the low/middle/high lane, and address 3 touches no lane. Each key select is encoded 0 = low, 1 = middle, 2 = high, and the staging and holding keys are set independently.
- R6: When `resValid` is high, `resData` is captured as the new holding result, and `holdReady` is high from the next cycle.
- R7: A read that includes the holding key lane returns data from the live result and locks that result into the read shadow. A read that does not include the key lane returns data from the read shadow.
- R8: A 16-bit read returns the low two lanes of the bus view. With `holdAlign`=0 the view is the result itself. With `holdAlign`=1 the view is the result shifted down by one lane, with a zero high lane.
- R9: A key-lane read clears `holdReady`. If a new result arrives in the same cycle, the flag stays set.
- R10: A result captured between the key read and the later lane reads does not change the bytes returned from the read shadow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busWr | input | 1 | Bus write to the staging register |
| busRd | input | 1 | Bus read from the holding register |
| busWide | input | 1 | 1 = 16-bit access, 0 = byte access |
| busAddr | input | 2 | Byte lane address for byte accesses |
| busWData | input | 16 | Write data; byte writes use bits 7:0 |
| busRData | output | 16 | Read data (combinational); byte reads return the byte in bits 7:0 |
| stageKey | input | 2 | Staging key lane select |
| holdKey | input | 2 | Holding key lane select |
| stageAlign | input | 1 | 16-bit writes target the upper two lanes |
| holdAlign | input | 1 | Upper 16 result bits are presented in the lower two lanes |
| engData | output | 24 | Committed sample to the engine |
| engValid | output | 1 | One-cycle strobe marking a new sample |
| resData | input | 24 | Result word from the engine |
| resValid | input | 1 | Result word present |
| holdReady | output | 1 | New result waiting to be read |

## Verification
Engine capture and the bus key-lane read can occur in the same cycle, and that collision affects both the ready flag and the read shadow. The bench drives `resValid` in the exact cycle of a key-lane read, and also between a key read and the non-key reads that follow it. It then checks three things: the flag stays set, the key read returns the older result, and the later lane reads still return bytes of that older word. A behavioural lane model in the bench predicts every readback, commit and flag value, and these are compared on every cycle over directed cases and a long random run.

// File: rtl/shp_pkg.sv
package shp_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 3;
  localparam int WORD_W = LANE_W * LANES;
  localparam int BUS_W  = 2 * LANE_W;
  localparam int SEL_W  = 2;

  typedef struct packed {
    logic [LANES-1:0] stgLanes;
    logic             stgCommit;
    logic             holdLock;
  } shp_strobe_t;
endpackage

// File: rtl/shp_ctrl.sv
module shp_ctrl
  import shp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             busWr,
  input  logic             busRd,
  input  logic             busWide,
  input  logic [SEL_W-1:0] busAddr,
  input  logic [SEL_W-1:0] stageKey,
  input  logic [SEL_W-1:0] holdKey,
  input  logic             stageAlign,
  input  logic             resValid,
  output shp_strobe_t      strobe,
  output logic             engValid,
  output logic             holdReady
);
  localparam logic [LANES-1:0] LOW_PAIR  = {{(LANES-2){1'b0}}, 2'b11};
  localparam logic [LANES-1:0] HIGH_PAIR = {2'b11, {(LANES-2){1'b0}}};

  logic [LANES-1:0] addrMask, stgKeyMask, holdKeyMask;
  logic [LANES-1:0] wrLanes, rdLanes;

  // one-hot decodes; out-of-range selects give an empty mask
  for (genvar i = 0; i < LANES; i++) begin : g_dec
    assign addrMask[i]    = (busAddr  == SEL_W'(i));
    assign stgKeyMask[i]  = (stageKey == SEL_W'(i));
    assign holdKeyMask[i] = (holdKey  == SEL_W'(i));
  end

  always_comb begin
    wrLanes = '0;
    rdLanes = '0;
    if (busWr) wrLanes = busWide ? (stageAlign ? HIGH_PAIR : LOW_PAIR) : addrMask;
    if (busRd) rdLanes = busWide ? LOW_PAIR : addrMask;
  end

  assign strobe.stgLanes  = wrLanes;
  assign strobe.stgCommit = |(wrLanes & stgKeyMask);
  assign strobe.holdLock  = |(rdLanes & holdKeyMask);

  always_ff @(posedge clk) begin
    if (rst) begin
      engValid  <= 1'b0;
      holdReady <= 1'b0;
    end else begin
      engValid <= strobe.stgCommit;
      if (resValid)             holdReady <= 1'b1;
      else if (strobe.holdLock) holdReady <= 1'b0;
    end
  end

  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busWr |=> !engValid); // R2
  AST_READY_ON_RESULT: assert property (@(posedge clk) disable iff (rst)
    resValid |=> holdReady); // R6
  AST_READY_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (busRd && strobe.holdLock && !resValid) |=> !holdReady); // R9
endmodule

// File: rtl/shp_data.sv
module shp_data
  import shp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  shp_strobe_t       strobe,
  input  logic              busRd,
  input  logic              busWide,
  input  logic [SEL_W-1:0]  busAddr,
  input  logic [BUS_W-1:0]  busWData,
  input  logic              stageAlign,
  input  logic              holdAlign,
  input  logic [WORD_W-1:0] resData,
  input  logic              resValid,
  output logic [WORD_W-1:0] engData,
  output logic [BUS_W-1:0]  busRData
);
  logic [WORD_W-1:0] stageShadow, merged;
  logic [WORD_W-1:0] holdReg, holdShadow, rdSrc, rdView;
  logic [LANE_W-1:0] byteSel;
  int unsigned       topLane;

  assign topLane = stageAlign ? (LANES - 1) : 1;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] laneIn;
    assign laneIn = (busWide && topLane == i) ? busWData[BUS_W-1:LANE_W]
                                              : busWData[LANE_W-1:0];
    assign merged[i*LANE_W +: LANE_W] = strobe.stgLanes[i] ? laneIn
                                        : stageShadow[i*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stageShadow <= '0;
      engData     <= '0;
      holdReg     <= '0;
      holdShadow  <= '0;
    end else begin
      stageShadow <= merged;
      if (strobe.stgCommit) engData    <= merged;
      if (resValid)         holdReg    <= resData;
      if (strobe.holdLock)  holdShadow <= holdReg;
    end
  end

  assign rdSrc  = strobe.holdLock ? holdReg : holdShadow;
  assign rdView = holdAlign ? {{LANE_W{1'b0}}, rdSrc[WORD_W-1:LANE_W]} : rdSrc;

  always_comb begin
    byteSel = '0;
    for (int i = 0; i < LANES; i++)
      if (busAddr == SEL_W'(i)) byteSel = rdView[i*LANE_W +: LANE_W];
  end

  always_comb begin
    busRData = '0;
    if (busRd) busRData = busWide ? rdView[BUS_W-1:0] : {{LANE_W{1'b0}}, byteSel};
  end

  AST_ENG_KEEPS: assert property (@(posedge clk) disable iff (rst)
    !strobe.stgCommit |=> $stable(engData)); // R2
  AST_COMMIT_WHOLE: assert property (@(posedge clk) disable iff (rst)
    strobe.stgCommit |=> (engData == stageShadow)); // R3
  AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !strobe.holdLock |=> $stable(holdShadow)); // R10
endmodule

// File: rtl/stage_hold_port.sv
module stage_hold_port
  import shp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              busWide,
  input  logic [SEL_W-1:0]  busAddr,
  input  logic [BUS_W-1:0]  busWData,
  output logic [BUS_W-1:0]  busRData,
  input  logic [SEL_W-1:0]  stageKey,
  input  logic [SEL_W-1:0]  holdKey,
  input  logic              stageAlign,
  input  logic              holdAlign,
  output logic [WORD_W-1:0] engData,
  output logic              engValid,
  input  logic [WORD_W-1:0] resData,
  input  logic              resValid,
  output logic              holdReady
);
  shp_strobe_t strobe;

  shp_ctrl u_ctrl (
    .clk, .rst, .busWr, .busRd, .busWide, .busAddr,
    .stageKey, .holdKey, .stageAlign, .resValid,
    .strobe, .engValid, .holdReady
  );

  shp_data u_data (
    .clk, .rst, .strobe, .busRd, .busWide, .busAddr, .busWData,
    .stageAlign, .holdAlign, .resData, .resValid,
    .engData, .busRData
  );
endmodule

// File: tb/sim_stage_hold_port.sv
module sim_stage_hold_port;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic busWr = 0, busRd = 0, busWide = 0;
  logic [1:0] busAddr = 0;
  logic [15:0] busWData = 0;
  logic [15:0] busRData;
  logic [1:0] stageKey = 1, holdKey = 1;
  logic stageAlign = 0, holdAlign = 0;
  logic [23:0] engData;
  logic engValid;
  logic [23:0] resData = 0;
  logic resValid = 0;
  logic holdReady;

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  // reference model state
  logic [7:0] mStg [3];
  logic [23:0] mEng = 0, mHold = 0, mShad = 0;
  logic mValid = 0, mFlag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stage_hold_port u0 (.*);

  task automatic check(string req, string what, logic [23:0] act, logic [23:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] laneSet(bit wide, logic [1:0] addr, bit hiPair);
    if (wide) return hiPair ? 3'b110 : 3'b011;
    case (addr)
      2'd0: return 3'b001;
      2'd1: return 3'b010;
      2'd2: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  task automatic step(string req, bit wr, bit rd, bit wide, logic [1:0] addr,
                      logic [15:0] wd, bit rv, logic [23:0] rdat);
    logic [2:0] wl, rl;
    logic [23:0] src, view;
    logic [15:0] expRd;
    bit commit, lock;
    @(negedge clk);
    busWr = wr; busRd = rd; busWide = wide; busAddr = addr; busWData = wd;
    resValid = rv; resData = rdat;
    wl = wr ? laneSet(wide, addr, stageAlign) : 3'b000;
    rl = rd ? laneSet(wide, addr, 1'b0) : 3'b000;
    commit = (stageKey < 3) && wl[stageKey];
    lock = (holdKey < 3) && rl[holdKey];
    src = lock ? mHold : mShad;
    view = holdAlign ? {8'h00, src[23:8]} : src;
    if (wide) expRd = view[15:0];
    else if (addr < 3) expRd = {8'h00, view[addr*8 +: 8]};
    else expRd = 16'h0000;
    #1;
    if (rd) check(req, "busRData", {8'h00, busRData}, {8'h00, expRd});
    @(posedge clk);
    for (int i = 0; i < 3; i++) if (wl[i]) begin
      if (wide && i == (stageAlign ? 2 : 1)) mStg[i] = wd[15:8];
      else mStg[i] = wd[7:0];
    end
    mValid = commit;
    if (commit) mEng = {mStg[2], mStg[1], mStg[0]};
    if (lock) mShad = mHold;
    if (rv) mHold = rdat;
    if (rv) mFlag = 1;
    else if (lock) mFlag = 0;
    #1;
    check(req, "engData", engData, mEng);
    check(req, "engValid", {23'd0, engValid}, {23'd0, mValid});
    check(req, "holdReady", {23'd0, holdReady}, {23'd0, mFlag});
  endtask

  task automatic idle(string req);
    step(req, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) mStg[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1: reset state, including readback
    step("R1", 0, 1, 1, 0, 0, 0, 0);
    step("R1", 0, 1, 0, 2, 0, 0, 0);
    // R2: non-key bytes with key = middle
    stageKey = 1;
    step("R2", 1, 0, 0, 0, 16'h0011, 0, 0);
    step("R2", 1, 0, 0, 2, 16'h0033, 0, 0);
    // R3: key byte commits the merged word, valid for one cycle
    step("R3", 1, 0, 0, 1, 16'h0022, 0, 0);
    idle("R3");
    // R4: 16-bit write, align off, touches middle (key) and low
    step("R4", 1, 0, 1, 0, 16'hA1B2, 0, 0);
    // R4 / R5: align on with key = low: high+middle written, no commit
    stageAlign = 1; stageKey = 0;
    step("R4", 1, 0, 1, 0, 16'hC3D4, 0, 0);
    step("R5", 1, 0, 0, 0, 16'h00E5, 0, 0);
    // R5: key = high commits on an aligned 16-bit write
    stageKey = 2;
    step("R5", 1, 0, 1, 0, 16'h5566, 0, 0);
    // R5: address 3 touches no lane
    step("R5", 1, 0, 0, 3, 16'h00FF, 0, 0);
    stageAlign = 0;
    // R6: capture a result
    holdKey = 1;
    step("R6", 0, 0, 0, 0, 0, 1, 24'hABCDEF);
    // R7: non-key lane read returns shadow (still reset value)
    step("R7", 0, 1, 0, 2, 0, 0, 0);
    // R7: key read returns live and locks
    step("R7", 0, 1, 1, 0, 0, 0, 0);
    // R10: new result arrives during a partial read
    step("R10", 0, 0, 0, 0, 0, 1, 24'h123456);
    step("R10", 0, 1, 0, 2, 0, 0, 0);
    step("R10", 0, 1, 0, 0, 0, 0, 0);
    // R9: key read clears the flag
    step("R9", 0, 1, 0, 1, 0, 0, 0);
    // R9: collision, set wins
    step("R9", 0, 0, 0, 0, 0, 1, 24'h789ABC);
    step("R9", 0, 1, 0, 1, 0, 1, 24'h0F1E2D);
    step("R9", 0, 1, 0, 2, 0, 0, 0);
    // R8: aligned holding view
    holdAlign = 1; holdKey = 0;
    step("R8", 0, 1, 1, 0, 0, 0, 0);
    step("R8", 0, 1, 0, 2, 0, 0, 0);
    step("R8", 0, 1, 0, 1, 0, 0, 0);
    holdAlign = 0; holdKey = 2;
    step("R5", 0, 1, 0, 2, 0, 1, 24'h334455);
    step("R5", 0, 1, 1, 0, 0, 0, 0);
    // R7: random mix of all traffic
    for (int n = 0; n < 400; n++) begin
      stageKey = 2'($urandom_range(0, 2));
      holdKey = 2'($urandom_range(0, 2));
      stageAlign = 1'($urandom);
      holdAlign = 1'($urandom);
      step("R7", 1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
           16'($urandom), 1'($urandom), 24'($urandom));
    end
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule